// File: doc/BRIEF.md
# Write-Enable and Block-Protect Status Unit

This unit keeps the eight-bit status word of a small serial-access nonvolatile memory. It owns the write-enable latch, the pair of block-protect bits that fence off nested upper regions of the array, and the write-in-progress indication. A serial front-end feeds it strobes for the set-latch and clear-latch commands, the data bits of a status-write transaction and the deselect that ends the transaction. A programming timer supplies a busy flag. The unit answers with the status byte for a status read, a permit flag for a candidate array address, and a one-cycle commit pulse when a status write has been accepted.

The protect bits stand for nonvolatile cells. They are ordinary flops with no reset, so they keep their value across the soft reset. Their power-up value comes from a parameter. When a status write is committed, the new protect code is staged. The old code stays visible until the programming timer has raised and then dropped its busy flag. Only the latch and busy bits are current during that window.

Top module: `stat_guard`

## Requirements
- R1: `status_byte` is always valid. Bits 7 to 4 read 1. Bit 3 is the upper protect bit and bit 2 the lower one. Bit 1 is the write-enable latch and bit 0 is write-in-progress, which equals `prog_busy` OR a pending status write.
- R2: Protect decode over `ADDR_W` address bits, with Q = 2^(ADDR_W-2). Code 00 protects nothing. Code 01 protects addresses at or above 3Q (0xC0 to 0xFF for 8 bits). Code 10 protects addresses at or above 2Q (0x80 to 0xFF). Code 11 protects every address.
- R3: The latch is set only by `wren_stb`, one cycle later. It is cleared one cycle later by `wrdi_stb`, by `wp_n` low, by an accepted status write or by an accepted array write. A clear condition wins over a set in the same cycle.
- R4: A status write is accepted only if `sr_cs_rise` arrives after exactly 8 `sr_bit_vld` bits since the last deselect or reset. A 7th-bit or 9th-bit deselect discards it. An acceptance gives `sr_commit` = 1 for exactly the cycle after `sr_cs_rise`.
- R5: From the cycle after the commit, write-in-progress reads 1 and the protect bits keep their old value. The new code, taken from data bits 3 (upper) and 2 (lower) of the byte sent MSB first, appears one cycle after `prog_busy` falls, once busy has been seen high during the pending write.
- R6: `wr_permit` = latch AND NOT write-in-progress AND `wp_n` AND NOT protected(`cand_addr`).
- R7: A status write or an `arr_wr_go` request is ignored, with no commit and no change to the latch, unless the latch is 1 and write-in-progress is 0 at that moment.
- R8: `rst_n` low clears the latch, the pending status write and the bit count. It leaves the protect bits unchanged. They start from `BP_INIT` (00 by default).
- R9: Once committed, a status write completes even if `wp_n` goes low or `wrdi_stb` arrives while it is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low soft reset |
| wren_stb | input | 1 | Set-latch command strobe |
| wrdi_stb | input | 1 | Clear-latch command strobe |
| wp_n | input | 1 | Write-protect pin, low blocks writes |
| sr_bit_vld | input | 1 | One status-write data bit latched this cycle |
| sr_bit | input | 1 | Value of that data bit |
| sr_cs_rise | input | 1 | Deselect ending a status-write transaction |
| arr_wr_go | input | 1 | Array write about to start (deselect at byte boundary) |
| prog_busy | input | 1 | Programming timer busy |
| cand_addr | input | ADDR_W | Candidate array write address |
| status_byte | output | 8 | Status word for a status read |
| wr_permit | output | 1 | Candidate address may be written now |
| sr_commit | output | 1 | One-cycle pulse: status write accepted |

## Verification
The bench builds the unit with `ADDR_W` = 8, the default comparator decode and `BP_INIT` = 00. The address space then has only 256 entries, so every address can be swept for every protect code. The permit flag is compared against thresholds that the bench computes from the quarter size. The narrow width also keeps the deselect-count cases (7, 8 and 9 bits) and the timing of the pending-write window small enough to be walked through cycle by cycle.

// File: rtl/sg_pkg.sv
`timescale 1ns/1ps
package sg_pkg;
   localparam int SR_BYTE_W = 8;

   typedef enum logic [1:0] {
      PROT_NONE     = 2'b00,
      PROT_TOP_QTR  = 2'b01,
      PROT_TOP_HALF = 2'b10,
      PROT_ALL      = 2'b11
   } prot_code_e;

   function automatic logic [SR_BYTE_W-1:0] pack_status(input logic [1:0] bp,
                                                        input logic wel,
                                                        input logic wip);
      return {4'hF, bp, wel, wip};
   endfunction
endpackage

// File: rtl/sg_wel_latch.sv
`timescale 1ns/1ps
module sg_wel_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_stb,
   input  logic clr_stb,
   input  logic wp_n,
   input  logic sr_exec,
   input  logic arr_exec,
   output logic wel
);
   logic clr_any;
   assign clr_any = clr_stb | ~wp_n | sr_exec | arr_exec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wel <= 1'b0;
      else if (clr_any) wel <= 1'b0;
      else if (set_stb) wel <= 1'b1;
   end

   AST_WP_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_n |=> !wel); // R3
   AST_WEL_SET_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(set_stb)); // R3
endmodule

// File: rtl/sg_prot_decode.sv
`timescale 1ns/1ps
module sg_prot_decode #(
   parameter int ADDR_W    = 8,
   parameter int DEC_STYLE = 0
) (
   input  logic [1:0]        bp,
   input  logic [ADDR_W-1:0] addr,
   output logic              prot
);
   import sg_pkg::*;

   generate
      if (ADDR_W < 2) begin : g_bad_w
         $error("sg_prot_decode: ADDR_W must be at least 2");
      end
      if (DEC_STYLE == 0) begin : g_cmp
         localparam logic [ADDR_W:0] QTR     = (ADDR_W+1)'(1) << (ADDR_W-2);
         localparam logic [ADDR_W:0] LIM_QTR = QTR * 3;
         localparam logic [ADDR_W:0] LIM_HLF = QTR * 2;
         logic [ADDR_W:0] a_ext;
         assign a_ext = {1'b0, addr};
         always_comb begin
            unique case (prot_code_e'(bp))
               PROT_NONE:     prot = 1'b0;
               PROT_TOP_QTR:  prot = (a_ext >= LIM_QTR);
               PROT_TOP_HALF: prot = (a_ext >= LIM_HLF);
               default:       prot = 1'b1;
            endcase
         end
      end else if (DEC_STYLE == 1) begin : g_msb
         logic [1:0] top2;
         assign top2 = addr[ADDR_W-1 -: 2];
         always_comb begin
            unique case (prot_code_e'(bp))
               PROT_NONE:     prot = 1'b0;
               PROT_TOP_QTR:  prot = &top2;
               PROT_TOP_HALF: prot = top2[1];
               default:       prot = 1'b1;
            endcase
         end
      end else begin : g_bad_style
         $error("sg_prot_decode: DEC_STYLE must be 0 or 1");
      end
   endgenerate
endmodule

// File: rtl/sg_sr_capture.sv
`timescale 1ns/1ps
module sg_sr_capture #(
   parameter int         SR_W    = 8,
   parameter logic [1:0] BP_INIT = 2'b00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_vld,
   input  logic       bit_in,
   input  logic       cs_rise,
   input  logic       wel,
   input  logic       busy,
   output logic [1:0] bp,
   output logic       pend,
   output logic       commit,
   output logic       sr_exec
);
   localparam int CNT_MAX = SR_W + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SR_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_MAX);

   generate
      if (SR_W < 4) begin : g_bad_w
         $error("sg_sr_capture: SR_W must be at least 4");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [3:0]       shf_q;
   logic [1:0]       staged_q;
   logic             saw_busy_q;
   logic             finish;
   logic [1:0]       bp_q = BP_INIT;

   assign sr_exec = cs_rise & (cnt_q == CNT_FULL) & wel & ~busy & ~pend;
   assign finish  = pend & saw_busy_q & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         shf_q <= '0;
      end else begin
         if (cs_rise)
            cnt_q <= '0;
         else if (bit_vld && cnt_q != CNT_SAT)
            cnt_q <= cnt_q + 1'b1;
         if (bit_vld)
            shf_q <= {shf_q[2:0], bit_in};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend       <= 1'b0;
         saw_busy_q <= 1'b0;
         staged_q   <= '0;
         commit     <= 1'b0;
      end else begin
         commit <= sr_exec;
         if (sr_exec) begin
            pend       <= 1'b1;
            saw_busy_q <= 1'b0;
            staged_q   <= shf_q[3:2];
         end else if (pend) begin
            if (busy)   saw_busy_q <= 1'b1;
            if (finish) pend       <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (finish) bp_q <= staged_q;
   end
   assign bp = bp_q;

   AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit); // R4
   AST_COMMIT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> pend); // R5
   AST_BP_ONLY_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_q != $past(bp_q)) |-> $past(pend)); // R5
endmodule

// File: rtl/stat_guard.sv
`timescale 1ns/1ps
module stat_guard #(
   parameter int         ADDR_W    = 8,
   parameter logic [1:0] BP_INIT   = 2'b00,
   parameter int         DEC_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wren_stb,
   input  logic              wrdi_stb,
   input  logic              wp_n,
   input  logic              sr_bit_vld,
   input  logic              sr_bit,
   input  logic              sr_cs_rise,
   input  logic              arr_wr_go,
   input  logic              prog_busy,
   input  logic [ADDR_W-1:0] cand_addr,
   output logic [7:0]        status_byte,
   output logic              wr_permit,
   output logic              sr_commit
);
   import sg_pkg::*;

   logic       wel, pend, wip, sr_exec, arr_exec, prot;
   logic [1:0] bp;

   assign wip      = prog_busy | pend;
   assign arr_exec = arr_wr_go & wel & ~wip;

   sg_wel_latch u_wel (
      .clk(clk), .rst_n(rst_n), .set_stb(wren_stb), .clr_stb(wrdi_stb),
      .wp_n(wp_n), .sr_exec(sr_exec), .arr_exec(arr_exec), .wel(wel)
   );

   sg_sr_capture #(.SR_W(SR_BYTE_W), .BP_INIT(BP_INIT)) u_cap (
      .clk(clk), .rst_n(rst_n), .bit_vld(sr_bit_vld), .bit_in(sr_bit),
      .cs_rise(sr_cs_rise), .wel(wel), .busy(prog_busy), .bp(bp),
      .pend(pend), .commit(sr_commit), .sr_exec(sr_exec)
   );

   sg_prot_decode #(.ADDR_W(ADDR_W), .DEC_STYLE(DEC_STYLE)) u_dec (
      .bp(bp), .addr(cand_addr), .prot(prot)
   );

   assign status_byte = pack_status(bp, wel, wip);
   assign wr_permit   = wel & ~wip & wp_n & ~prot;

   AST_PERMIT_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_permit |-> (!prot && !pend)); // R6
   AST_ARR_EXEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      arr_exec |=> !wel); // R3
   AST_COMMIT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      sr_commit |-> ($past(wel) && !$past(prog_busy))); // R7
endmodule

// File: tb/tb_stat_guard.sv
`timescale 1ns/1ps
module tb_stat_guard;
   localparam int AW = 8;

   logic clk = 1'b0;
   logic rst_n, wren_stb, wrdi_stb, wp_n, sr_bit_vld, sr_bit, sr_cs_rise;
   logic arr_wr_go, prog_busy;
   logic [AW-1:0] cand_addr;
   logic [7:0] status_byte;
   logic wr_permit, sr_commit;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic [1:0] exp_bp = 2'b00;
   logic got_commit;

   always #2 clk = ~clk;

   stat_guard #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
      .wp_n(wp_n), .sr_bit_vld(sr_bit_vld), .sr_bit(sr_bit),
      .sr_cs_rise(sr_cs_rise), .arr_wr_go(arr_wr_go), .prog_busy(prog_busy),
      .cand_addr(cand_addr), .status_byte(status_byte),
      .wr_permit(wr_permit), .sr_commit(sr_commit)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total = total + 1;
      if (act != exp) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic is_prot(input int a, input logic [1:0] b);
      int q = (1 << AW) / 4;
      case (b)
         2'b00:   return 1'b0;
         2'b01:   return a >= 3 * q;
         2'b10:   return a >= 2 * q;
         default: return 1'b1;
      endcase
   endfunction

   task automatic cyc1(); @(negedge clk); endtask

   task automatic do_wren(); wren_stb = 1; cyc1(); wren_stb = 0; endtask
   task automatic do_wrdi(); wrdi_stb = 1; cyc1(); wrdi_stb = 0; endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         sr_bit_vld = 1;
         sr_bit = (i < 8) ? b[7-i] : 1'b1;
         cyc1();
      end
      sr_bit_vld = 0;
   endtask

   task automatic deselect();
      sr_cs_rise = 1; cyc1(); sr_cs_rise = 0;
      got_commit = sr_commit;
   endtask

   task automatic busy_run(input int n);
      prog_busy = 1;
      repeat (n) cyc1();
      prog_busy = 0;
      cyc1();
   endtask

   task automatic sweep(input string req, input logic wel_e);
      for (int a = 0; a < (1 << AW); a++) begin
         cand_addr = AW'(a);
         #1;
         chk(req, wr_permit, wel_e & wp_n & ~is_prot(a, exp_bp));
         cyc1();
      end
   endtask

   initial begin
      rst_n = 0; wren_stb = 0; wrdi_stb = 0; wp_n = 1; sr_bit_vld = 0;
      sr_bit = 0; sr_cs_rise = 0; arr_wr_go = 0; prog_busy = 0;
      cand_addr = '0; got_commit = 0;
      repeat (3) cyc1();
      rst_n = 1;
      cyc1();
      chk("R1 R8 reset status", status_byte, 8'hF0);
      chk("R4 no commit at reset", sr_commit, 0);

      do_wren();
      chk("R3 set by wren", status_byte, 8'hF2);
      do_wrdi();
      chk("R3 cleared by wrdi", status_byte, 8'hF0);
      do_wren();
      wren_stb = 1; wrdi_stb = 1; cyc1(); wren_stb = 0; wrdi_stb = 0;
      chk("R3 clear wins over set", status_byte, 8'hF0);
      do_wren();
      wp_n = 0; cyc1(); wp_n = 1;
      chk("R3 wp low clears latch", status_byte, 8'hF0);

      send_bits(8'h0C, 8); deselect();
      chk("R7 status write without latch", got_commit, 0);
      chk("R7 status unchanged", status_byte, 8'hF0);

      do_wren();
      send_bits(8'h0C, 9); deselect();
      chk("R4 nine bits discarded", got_commit, 0);
      chk("R4 latch kept after discard", status_byte, 8'hF2);
      send_bits(8'h0C, 7); deselect();
      chk("R4 seven bits discarded", got_commit, 0);

      send_bits(8'h0C, 4);
      wp_n = 0; cyc1(); wp_n = 1;
      send_bits(8'h0C, 4); deselect();
      chk("R3 wp low mid-write blocks commit", got_commit, 0);
      chk("R3 latch cleared by wp", status_byte, 8'hF0);

      do_wren();
      send_bits(8'h04, 8); deselect();
      chk("R4 eight bits commit", got_commit, 1);
      chk("R5 old bp while pending", status_byte, 8'hF1);
      cyc1();
      chk("R4 commit is one pulse", sr_commit, 0);
      wp_n = 0; cyc1(); wp_n = 1;
      do_wrdi();
      prog_busy = 1; cyc1();
      chk("R1 readable during busy", status_byte, 8'hF1);
      cyc1(); prog_busy = 0;
      #1;
      chk("R5 wip held until finish", status_byte[0], 1);
      cyc1();
      exp_bp = 2'b01;
      chk("R5 R9 new bp after busy falls", status_byte, 8'hF4);

      do_wren();
      prog_busy = 1;
      cand_addr = '0;
      cyc1();
      chk("R6 no permit while busy", wr_permit, 0);
      arr_wr_go = 1; cyc1(); arr_wr_go = 0;
      chk("R7 array write ignored while busy", status_byte, 8'hF7);
      prog_busy = 0; cyc1();
      chk("R1 latch bit after busy", status_byte, 8'hF6);
      sweep("R2 R6 sweep code 01", 1'b1);
      arr_wr_go = 1; cyc1(); arr_wr_go = 0;
      chk("R3 array write clears latch", status_byte, 8'hF4);

      for (int k = 0; k < 3; k++) begin
         logic [1:0] code;
         code = (k == 0) ? 2'b00 : (k == 1) ? 2'b10 : 2'b11;
         do_wren();
         send_bits({4'h0, code, 2'b00}, 8); deselect();
         chk("R4 commit in code loop", got_commit, 1);
         busy_run(2);
         exp_bp = code;
         chk("R5 bp after write", status_byte, {4'hF, code, 2'b00});
         do_wren();
         sweep("R2 R6 sweep", 1'b1);
         wp_n = 0; cand_addr = '0; #1;
         chk("R6 wp low blocks permit", wr_permit, 0);
         cyc1(); wp_n = 1;
      end

      rst_n = 0; cyc1(); rst_n = 1; cyc1();
      chk("R8 reset keeps bp", status_byte, 8'hFC);

      do_wren();
      send_bits(8'h00, 8); deselect();
      chk("R4 commit before reset", got_commit, 1);
      rst_n = 0; cyc1(); rst_n = 1; cyc1();
      chk("R8 reset drops pending write", status_byte, 8'hFC);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule